// File: doc/BRIEF.md
# Single-Line Condition Waiter with Tick Timeout

This block watches one asynchronous digital line and tells its requester when a chosen event happens on it. A request picks one of five events: a rising transition, a falling transition, a transition in either direction, the line being high, or the line being low. The request also carries a signed tick budget. The block then reports, with a one-cycle completion pulse, whether the event was seen or whether the budget ran out first.

A budget of zero gives an answer at once with the timed-out flag set. A negative budget turns the timeout off, so the wait lasts until the event happens. A positive budget N allows at most N active clock cycles. The line passes through two synchronizing flops. Transitions are found by comparing the newest synchronized sample with the one before it. A requester pulses `start` while the block is idle. It watches `busy` during the wait, then reads `timed_out` in the cycle where `done` is high.

Top module: `line_waiter`

## Requirements
- R1: Event codes on `cond`: 0 = rising, 1 = falling, 2 = either transition, 3 = line high, 4 = line low. Codes 5, 6 and 7 never match, so such a wait can end only by timeout.
- R2: The line is sampled through two flops plus one history flop. A change on `line` that is driven just after a falling clock edge is acted on at the third following rising edge, and `done` goes high after that edge.
- R3: A start with `timeout` equal to 0 sets `done` and `timed_out` for the cycle after the start edge. `busy` is never raised for that request.
- R4: A negative `timeout` never expires. The wait lasts until the event occurs.
- R5: A positive `timeout` N with no event ends with `done` and `timed_out` high after the Nth rising edge following the start edge.
- R6: A transition event must be observed during the wait. A level event that already holds completes on the first active edge, so `done` is high one cycle after the start edge.
- R7: A `start` pulse while `busy` is high is ignored. It changes neither the running wait's outcome nor its timing.
- R8: `done` lasts one cycle per request. `timed_out` is high only together with `done`. `busy` is low in the `done` cycle.
- R9: If the event and the expiry of the budget fall on the same edge, the event wins and `timed_out` stays low.
- R10: Synchronous active-high `rst` returns the block to idle with `busy`, `done` and `timed_out` low. This also aborts a running wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; timeout ticks count its rising edges |
| rst | input | 1 | Synchronous active-high reset |
| line | input | 1 | Asynchronous digital line being watched |
| start | input | 1 | Request pulse, accepted only when idle |
| cond | input | 3 | Event code (see R1) |
| timeout | input | TW | Signed tick budget (see R3 to R5) |
| busy | output | 1 | High while a wait is running |
| done | output | 1 | One-cycle completion pulse |
| timed_out | output | 1 | High with `done` when the budget ran out |

## Verification
A wrong countdown value or a lost infinite flag shows up as `done` one or more cycles too early or too late, or as a wait that never ends. The sweep therefore checks the exact cycle of `done` against an arithmetic prediction, not only whether it occurs. A bad synchronizer or history flop moves or invents transition hits, which appear within three cycles of a line change. A latched code corrupted by a stray start changes which line pattern ends the wait, and that is visible in the same request.

// File: rtl/line_waiter.sv
module line_waiter #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line,
  input  logic          start,
  input  logic [2:0]    cond,
  input  logic [TW-1:0] timeout,
  output logic          busy,
  output logic          done,
  output logic          timed_out
);

  localparam int CW = TW - 1;

  logic          sync_a, sync_b, hist;
  logic          active;
  logic [2:0]    code_q;
  logic          forever_q;
  logic [CW-1:0] left;
  logic          done_q, to_q;
  logic          hit;

  wire rise = sync_b & ~hist;
  wire fall = ~sync_b & hist;
  wire last_tick = !forever_q && left == CW'(1);

  always_comb begin
    case (code_q)
      3'd0:    hit = rise;
      3'd1:    hit = fall;
      3'd2:    hit = rise | fall;
      3'd3:    hit = sync_b;
      3'd4:    hit = ~sync_b;
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a    <= 1'b0;
      sync_b    <= 1'b0;
      hist      <= 1'b0;
      active    <= 1'b0;
      code_q    <= 3'd0;
      forever_q <= 1'b0;
      left      <= '0;
      done_q    <= 1'b0;
      to_q      <= 1'b0;
    end else begin
      sync_a <= line;
      sync_b <= sync_a;
      hist   <= sync_b;
      done_q <= 1'b0;
      to_q   <= 1'b0;
      if (!active) begin
        if (start) begin
          if (timeout == '0) begin
            done_q <= 1'b1;
            to_q   <= 1'b1;
          end else begin
            active    <= 1'b1;
            code_q    <= cond;
            forever_q <= timeout[TW-1];
            left      <= timeout[CW-1:0];
          end
        end
      end else if (hit) begin
        active <= 1'b0;
        done_q <= 1'b1;
      end else if (last_tick) begin
        active <= 1'b0;
        done_q <= 1'b1;
        to_q   <= 1'b1;
      end else if (!forever_q) begin
        left <= left - CW'(1);
      end
    end
  end

  assign busy      = active;
  assign done      = done_q;
  assign timed_out = to_q;

  assert_code_dead_R1: assert property (@(posedge clk) disable iff (rst)
    (active && code_q > 3'd4) |-> !hit);
  assert_zero_budget_R3: assert property (@(posedge clk) disable iff (rst)
    (!active && start && timeout == '0) |=> (done && timed_out && !busy));
  assert_no_expiry_R4: assert property (@(posedge clk) disable iff (rst)
    (active && forever_q && !hit) |=> busy);
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (active && start) |=> ($stable(code_q) && $stable(forever_q)));
  assert_flag_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    timed_out |-> done);
  assert_idle_on_done_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_event_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (active && hit && last_tick) |=> (done && !timed_out));
  assert_reset_idle_R10: assert property (@(posedge clk)
    rst |=> (!busy && !done && !timed_out));

endmodule

// File: tb/line_waiter_bench.sv
module line_waiter_bench;
  localparam int TW = 32;
  localparam int NEVER = 1000000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line = 1'b0;
  logic start = 1'b0;
  logic [2:0] cond = 3'd0;
  logic [TW-1:0] timeout = '0;
  logic busy, done, timed_out;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  line_waiter #(.TW(TW)) u_line_waiter (
    .clk(clk), .rst(rst), .line(line), .start(start), .cond(cond),
    .timeout(timeout), .busy(busy), .done(done), .timed_out(timed_out)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual busy/done/to=%b expected=%b", req, act, exp);
    end
  endtask

  // Idle line at l0, start a wait, change line to l1 at negedge index d.
  task automatic run(input int c, input int t, input logic l0, input logic l1,
                     input int d, input bit poke);
    int kmet, kexp;
    bit eto;
    bit hit_first, hit_later;
    line = l0;
    repeat (4) @(negedge clk);
    hit_first = (c == 3 && l0) || (c == 4 && !l0);
    hit_later = (l0 != l1) && ((c == 0 && l1) || (c == 1 && !l1) || c == 2 ||
                (c == 3 && l1) || (c == 4 && !l1));
    kmet = hit_first ? 1 : (hit_later ? d + 3 : NEVER);
    if (t == 0) begin kexp = 0; eto = 1; end
    else if (t < 0) begin kexp = kmet; eto = 0; end
    else if (kmet <= t) begin kexp = kmet; eto = 0; end
    else begin kexp = t; eto = 1; end
    cond = 3'(c);
    timeout = TW'(t);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j <= kexp + 2; j++) begin
      if (j > 0) @(negedge clk);
      // R1 R2 R3 R4 R5 R6 R8 R9: exact cycle and flag of completion
      check($sformatf("R1/R5/R9 c=%0d t=%0d l0=%0d l1=%0d d=%0d j=%0d", c, t, l0, l1, d, j),
            {busy, done, timed_out},
            {(j < kexp), (j == kexp), (j == kexp) && eto});
      if (j == d) line = l1;
      if (poke && kexp > 2 && j == 1) begin
        start = 1'b1; cond = 3'(c + 3); timeout = '0; // R7
      end
      if (j == 2) start = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset state", {busy, done, timed_out}, 3'b000);

    foreach (int_dummy[i]) ;
    for (int c = 0; c < 8; c++)
      for (int l0 = 0; l0 < 2; l0++)
        for (int l1 = 0; l1 < 2; l1++)
          for (int d = 0; d < 4; d += 2)
            for (int ti = 0; ti < 6; ti++) begin
              int t;
              bit can;
              t = (ti == 5) ? -1 : (ti == 4 ? 5 : ti);
              can = (c == 3 && l0) || (c == 4 && !l0) ||
                    ((l0 != l1) && (c < 5) &&
                     !((c == 0 && !l1) || (c == 1 && l1) || (c == 3 && !l1) || (c == 4 && l1)));
              if (t >= 0 || can) run(c, t, 1'(l0), 1'(l1), d, (ti % 2) == 1);
            end

    // R4: unbounded wait far longer than any finite budget above
    run(0, -1, 1'b0, 1'b1, 40, 1'b1);
    run(2, -7, 1'b1, 1'b0, 25, 1'b0);
    // R9: event and expiry on the same edge
    run(1, 4, 1'b1, 1'b0, 1, 1'b0);
    run(3, 3, 1'b0, 1'b1, 0, 1'b0);

    // R10: reset aborts a running wait
    line = 1'b0;
    repeat (4) @(negedge clk);
    cond = 3'd0; timeout = '1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R10 waiting before reset", {busy, done, timed_out}, 3'b100);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 aborted by reset", {busy, done, timed_out}, 3'b000);
    line = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 no completion after abort", {busy, done, timed_out}, 3'b000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  int int_dummy[1];
endmodule